// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block answers a three-strobe interrupt acknowledge handshake. A host processor lowers an active-low acknowledge strobe three times in a row. On each low phase the sequencer drives one byte onto the shared data bus. The first byte is a fixed call opcode. The second is the low byte of the service routine address. The third is the high byte of that address.

The level to serve is taken from an external priority resolver on the first strobe and held for the rest of the sequence. The low byte is formed by inserting that 3-bit level into a programmed base address. The level's position depends on whether handlers sit 4 or 8 bytes apart. If the resolver reports no valid request when the first strobe arrives, the sequencer serves level 7.

The block also keeps the in-service register. It sets the served level's bit on the first strobe. With automatic end-of-interrupt selected, it clears that bit when the last strobe ends. Otherwise the bit stays set until an end-of-interrupt command clears the highest-priority set bit. The acknowledge strobe is sampled on the clock. Every result appears one clock edge after the strobe edge that causes it.

Top module: `irq_vector_seq`

## Requirements
- R1: During the first low strobe of a sequence, the data bus carries 0xCD.
- R2: With the interval select at 0 (4-byte spacing), the second byte is base[7:5] on bits 7..5, the level on bits 4..2, and zeros on bits 1..0.
- R3: With the interval select at 1 (8-byte spacing), the second byte is base[7:6] on bits 7..6, the level on bits 5..3, and zeros on bits 2..0.
- R4: During the third low strobe, the data bus carries base[15:8].
- R5: If req_valid_i is low when the first strobe is sampled, the sequence serves level 7, and no request-clear pulse is issued.
- R6: On the first strobe, the in-service bit of the served level is set. With a valid request, req_clr_o pulses for one cycle with exactly that level's bit (bit n for level n) set.
- R7: With automatic end-of-interrupt configured, the served in-service bit clears when the third strobe returns high. Without it, the bit stays set.
- R8: data_oe_o is high only in cycles whose previous clock edge sampled the strobe low during an active sequence. data_o is zero whenever data_oe_o is low.
- R9: After reset, the in-service register is zero, the sequence is idle, and the base address, interval select and automatic end-of-interrupt flag are all zero.
- R10: A one-cycle eoi_i pulse clears the lowest-numbered set in-service bit. Level 0 has the highest priority.
- R11: The level is captured on the first strobe. Changes on req_level_i later in the sequence do not alter the bytes driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ack_ni | input | 1 | Interrupt acknowledge strobe, active low |
| cfg_we_i | input | 1 | Loads the configuration fields below |
| cfg_base_i | input | 16 | Programmed vector base address |
| cfg_iv8_i | input | 1 | Interval select: 0 = 4-byte, 1 = 8-byte |
| cfg_aeoi_i | input | 1 | Automatic end-of-interrupt enable |
| req_valid_i | input | 1 | Resolver reports a pending request |
| req_level_i | input | 3 | Resolved highest-priority level |
| eoi_i | input | 1 | End-of-interrupt command pulse |
| data_o | output | 8 | Vector byte |
| data_oe_o | output | 1 | Data bus drive enable |
| isr_o | output | 8 | In-service register |
| req_clr_o | output | 8 | One-hot clear for the served request bit |

## Verification
Every output is registered one clock edge behind the strobe edge that causes it. This applies to the byte and drive enable after a falling strobe, the in-service set and request-clear pulse on the first falling strobe, and the drive-enable drop and automatic clear after the third rising strobe. The bench changes the strobe on a falling clock edge and samples on the next falling clock edge, exactly one rising edge later. An end-of-interrupt pulse is held for one cycle and the register is read at the following falling edge. Each scenario starts from a fresh reset, so in-service contents are known exactly.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_B1   = 2'd1,
    PH_B2   = 2'd2,
    PH_B3   = 2'd3
  } ack_phase_e;

  localparam logic [7:0] CALL_OP = 8'hCD;
endpackage

// File: rtl/ack_phase_ctrl.sv
module ack_phase_ctrl
  import irq_vec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ack_ni,
  output logic       ack_q_o,
  output logic       first_o,
  output logic       last_end_o,
  output ack_phase_e phase_o
);
  logic       ack_q;
  logic       fall, rise;
  ack_phase_e phase_q, phase_d;

  assign fall = ack_q & ~ack_ni;
  assign rise = ~ack_q & ack_ni;

  always_comb begin
    phase_d = phase_q;
    if (fall) begin
      unique case (phase_q)
        PH_IDLE: phase_d = PH_B1;
        PH_B1:   phase_d = PH_B2;
        PH_B2:   phase_d = PH_B3;
        default: phase_d = PH_B3;
      endcase
    end else if (rise && phase_q == PH_B3) begin
      phase_d = PH_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b1;
      phase_q <= PH_IDLE;
    end else begin
      ack_q   <= ack_ni;
      phase_q <= phase_d;
    end
  end

  assign ack_q_o    = ack_q;
  assign first_o    = fall && (phase_q == PH_IDLE);
  assign last_end_o = rise && (phase_q == PH_B3);
  assign phase_o    = phase_q;
endmodule

// File: rtl/isr_track.sv
module isr_track #(
  parameter int NUM_LVL = 8,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  logic [LVL_W-1:0]   set_lvl_i,
  input  logic               auto_clr_i,
  input  logic [LVL_W-1:0]   clr_lvl_i,
  input  logic               eoi_i,
  output logic [NUM_LVL-1:0] isr_o
);
  logic [NUM_LVL-1:0] isr_q, set_mask, auto_mask, eoi_mask, low_bit;

  // lowest set bit = highest priority
  assign low_bit   = isr_q & (~isr_q + NUM_LVL'(1));
  assign eoi_mask  = eoi_i ? low_bit : '0;
  assign set_mask  = set_i ? (NUM_LVL'(1) << set_lvl_i) : '0;
  assign auto_mask = auto_clr_i ? (NUM_LVL'(1) << clr_lvl_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (isr_q & ~eoi_mask & ~auto_mask) | set_mask;
  end

  assign isr_o = isr_q;
endmodule

// File: rtl/vec_byte_mux.sv
module vec_byte_mux
  import irq_vec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LVL_W  = 3
) (
  input  ack_phase_e        phase_i,
  input  logic              drive_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              iv8_i,
  output logic [7:0]        data_o
);
  logic [7:0] low_iv4, low_iv8, sel;

  assign low_iv4 = {base_i[7:5], lvl_i, 2'b00};
  assign low_iv8 = {base_i[7:6], lvl_i, 3'b000};

  always_comb begin
    unique case (phase_i)
      PH_B1:   sel = CALL_OP;
      PH_B2:   sel = iv8_i ? low_iv8 : low_iv4;
      PH_B3:   sel = base_i[15:8];
      default: sel = 8'h00;
    endcase
  end

  assign data_o = drive_i ? sel : 8'h00;
endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq
  import irq_vec_pkg::*;
#(
  parameter int NUM_LVL = 8,
  parameter int ADDR_W  = 16,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ack_ni,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_base_i,
  input  logic               cfg_iv8_i,
  input  logic               cfg_aeoi_i,
  input  logic               req_valid_i,
  input  logic [LVL_W-1:0]   req_level_i,
  input  logic               eoi_i,
  output logic [7:0]         data_o,
  output logic               data_oe_o,
  output logic [NUM_LVL-1:0] isr_o,
  output logic [NUM_LVL-1:0] req_clr_o
);
  logic [ADDR_W-1:0]  base_q;
  logic               iv8_q, aeoi_q;
  logic [LVL_W-1:0]   lvl_q, lvl_pick;
  logic [NUM_LVL-1:0] req_clr_q;
  logic               ack_q, first, last_end;
  ack_phase_e         phase;

  ack_phase_ctrl u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ack_ni     (ack_ni),
    .ack_q_o    (ack_q),
    .first_o    (first),
    .last_end_o (last_end),
    .phase_o    (phase)
  );

  // vanished request falls back to the lowest-priority level
  assign lvl_pick = req_valid_i ? req_level_i : LVL_W'(NUM_LVL - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q    <= '0;
      iv8_q     <= 1'b0;
      aeoi_q    <= 1'b0;
      lvl_q     <= '0;
      req_clr_q <= '0;
    end else begin
      if (cfg_we_i) begin
        base_q <= cfg_base_i;
        iv8_q  <= cfg_iv8_i;
        aeoi_q <= cfg_aeoi_i;
      end
      if (first) lvl_q <= lvl_pick;
      req_clr_q <= (first && req_valid_i) ? (NUM_LVL'(1) << req_level_i) : '0;
    end
  end

  isr_track #(.NUM_LVL(NUM_LVL)) u_isr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (first),
    .set_lvl_i  (lvl_pick),
    .auto_clr_i (last_end && aeoi_q),
    .clr_lvl_i  (lvl_q),
    .eoi_i      (eoi_i),
    .isr_o      (isr_o)
  );

  assign data_oe_o = ~ack_q && (phase != PH_IDLE);

  vec_byte_mux #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_mux (
    .phase_i (phase),
    .drive_i (data_oe_o),
    .lvl_i   (lvl_q),
    .base_i  (base_q),
    .iv8_i   (iv8_q),
    .data_o  (data_o)
  );

  assign req_clr_o = req_clr_q;
endmodule

// File: rtl/irq_vector_seq_chk.sv
module irq_vector_seq_chk
  import irq_vec_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ack_ni,
  input logic       req_valid_i,
  input logic [7:0] data_o,
  input logic       data_oe_o,
  input logic [7:0] isr_o,
  input logic [7:0] req_clr_o,
  input ack_phase_e phase,
  input logic [2:0] lvl_q,
  input logic       aeoi_q
);
  assert_oe_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> $past(!ack_ni));

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == 8'h00);

  assert_call_byte_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(data_oe_o) && $past(phase == PH_IDLE)) |-> data_o == CALL_OP);

  assert_clr_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_clr_o));

  assert_clr_sets_isr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_clr_o != 8'h00) |-> ((isr_o & req_clr_o) == req_clr_o));

  assert_clr_needs_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_clr_o != 8'h00) |-> $past(req_valid_i));

  assert_auto_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aeoi_q && $past(aeoi_q) && $past(phase == PH_B3) && phase == PH_IDLE)
      |-> !isr_o[lvl_q]);
endmodule

bind irq_vector_seq irq_vector_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ack_ni      (ack_ni),
  .req_valid_i (req_valid_i),
  .data_o      (data_o),
  .data_oe_o   (data_oe_o),
  .isr_o       (isr_o),
  .req_clr_o   (req_clr_o),
  .phase       (phase),
  .lvl_q       (lvl_q),
  .aeoi_q      (aeoi_q)
);

// File: tb/irq_vector_seq_bench.sv
`timescale 1ns/1ps
module irq_vector_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ack_ni = 1'b1;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_base_i = '0;
  logic        cfg_iv8_i = 1'b0;
  logic        cfg_aeoi_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  req_level_i = '0;
  logic        eoi_i = 1'b0;
  logic [7:0]  data_o;
  logic        data_oe_o;
  logic [7:0]  isr_o;
  logic [7:0]  req_clr_o;

  int total = 0;
  int bad = 0;

  always #10 clk_i = ~clk_i;

  irq_vector_seq u_irq_vector_seq (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; ack_ni = 1'b1; cfg_we_i = 1'b0; eoi_i = 1'b0;
    req_valid_i = 1'b0; req_level_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic configure(input logic [15:0] base, input logic iv8, input logic aeoi);
    cfg_base_i = base; cfg_iv8_i = iv8; cfg_aeoi_i = aeoi; cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // one strobe: low for one edge, then high for one edge
  task automatic strobe(output logic [7:0] b, output logic oe_lo, output logic [7:0] clr,
                        output logic oe_hi);
    ack_ni = 1'b0;
    @(negedge clk_i);
    b = data_o; oe_lo = data_oe_o; clr = req_clr_o;
    ack_ni = 1'b1;
    @(negedge clk_i);
    oe_hi = data_oe_o;
  endtask

  task automatic full_seq(output logic [7:0] b1, output logic [7:0] b2,
                          output logic [7:0] b3, output logic [7:0] clr);
    logic oe_l, oe_h;
    logic [7:0] c;
    strobe(b1, oe_l, clr, oe_h);
    strobe(b2, oe_l, c, oe_h);
    strobe(b3, oe_l, c, oe_h);
  endtask

  task automatic pulse_eoi();
    eoi_i = 1'b1;
    @(negedge clk_i);
    eoi_i = 1'b0;
  endtask

  task automatic test_reset();
    logic [7:0] b1, b2, b3, clr;
    do_reset();
    chk("R9 isr", isr_o, 8'h00);
    chk("R9 oe", data_oe_o, 1'b0);
    chk("R8 data idle", data_o, 8'h00);
    req_valid_i = 1'b1; req_level_i = 3'd3;
    full_seq(b1, b2, b3, clr);
    chk("R1 byte1", b1, 8'hCD);
    chk("R9 zero base low", b2, 8'h0C);
    chk("R9 zero base high", b3, 8'h00);
    chk("R9 no aeoi", isr_o, 8'h08);
  endtask

  task automatic test_iv4_aeoi();
    logic [7:0] b1, b2, b3, clr;
    logic oe_l, oe_h;
    do_reset();
    configure(16'h12E0, 1'b0, 1'b1);
    req_valid_i = 1'b1; req_level_i = 3'd5;
    strobe(b1, oe_l, clr, oe_h);
    chk("R1 byte1", b1, 8'hCD);
    chk("R8 oe low strobe", oe_l, 1'b1);
    chk("R8 oe high strobe", oe_h, 1'b0);
    chk("R6 req clr", clr, 8'h20);
    chk("R6 isr set", isr_o, 8'h20);
    chk("R6 clr one cycle", req_clr_o, 8'h00);
    strobe(b2, oe_l, clr, oe_h);
    chk("R2 byte2", b2, 8'hF4);
    chk("R6 isr mid", isr_o, 8'h20);
    strobe(b3, oe_l, clr, oe_h);
    chk("R4 byte3", b3, 8'h12);
    chk("R7 aeoi cleared", isr_o, 8'h00);
    chk("R8 oe after", data_oe_o, 1'b0);
  endtask

  task automatic test_iv8();
    logic [7:0] b1, b2, b3, clr;
    do_reset();
    configure(16'hBEC0, 1'b1, 1'b0);
    req_valid_i = 1'b1; req_level_i = 3'd2;
    full_seq(b1, b2, b3, clr);
    chk("R1 byte1", b1, 8'hCD);
    chk("R3 byte2", b2, 8'hD0);
    chk("R4 byte3", b3, 8'hBE);
    chk("R7 held without aeoi", isr_o, 8'h04);
    repeat (3) @(negedge clk_i);
    chk("R7 still held", isr_o, 8'h04);
  endtask

  task automatic test_no_req();
    logic [7:0] b1, b2, b3, clr;
    do_reset();
    configure(16'h3460, 1'b0, 1'b0);
    req_valid_i = 1'b0; req_level_i = 3'd1;
    full_seq(b1, b2, b3, clr);
    chk("R5 byte2 level7", b2, 8'h7C);
    chk("R5 byte3", b3, 8'h34);
    chk("R5 no clr", clr, 8'h00);
    chk("R5 isr7", isr_o, 8'h80);
  endtask

  task automatic test_latch();
    logic [7:0] b, c;
    logic oe_l, oe_h;
    do_reset();
    configure(16'h0000, 1'b1, 1'b0);
    req_valid_i = 1'b1; req_level_i = 3'd2;
    strobe(b, oe_l, c, oe_h);
    req_level_i = 3'd6;
    strobe(b, oe_l, c, oe_h);
    chk("R11 level held", b, 8'h10);
    strobe(b, oe_l, c, oe_h);
    chk("R11 isr", isr_o, 8'h04);
  endtask

  task automatic test_eoi();
    logic [7:0] b1, b2, b3, clr;
    do_reset();
    configure(16'h0000, 1'b0, 1'b0);
    req_valid_i = 1'b1;
    req_level_i = 3'd6; full_seq(b1, b2, b3, clr);
    req_level_i = 3'd1; full_seq(b1, b2, b3, clr);
    req_level_i = 3'd4; full_seq(b1, b2, b3, clr);
    chk("R10 setup", isr_o, 8'h52);
    pulse_eoi();
    chk("R10 clears level1", isr_o, 8'h50);
    pulse_eoi();
    chk("R10 clears level4", isr_o, 8'h40);
    pulse_eoi();
    chk("R10 clears level6", isr_o, 8'h00);
  endtask

  initial begin
    #(20ns * 100000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    test_iv4_aeoi();
    test_iv8();
    test_no_req();
    test_latch();
    test_eoi();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule